// File: doc/BRIEF.md
# Receive Byte Queue with Trigger and Timeout Flags

This block buffers received characters for a serial port. Once per character time a strobe marks the moment a new byte may arrive, either from the line deserializer or, in loopback mode, from the transmit side of the same port. The CPU drains the queue through a read port that always shows the oldest byte and removes it on a read strobe. The current occupancy is visible at all times.

Three status flags summarise the queue for software. A fill flag rises when a newly stored byte brings the occupancy up to a programmable trigger level. A timeout-style data-ready flag rises when bytes sit below that level and the line has been quiet for two character times. An overrun flag records that a byte arrived while the queue was full. The fill and data-ready flags drive a receive interrupt, and the overrun flag drives an error interrupt, each gated by its own enable. Software clears flags by writing zero to them and can flush the queue with a reset pulse.

Top module: `rx_trigger_fifo`

## Requirements
- R1: The queue stores up to DEPTH (default 16) bytes and returns them in arrival order on `rd_data`; `rx_count` always shows the number of stored bytes.
- R2: `trig_sel` picks the trigger level: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R3: When a byte is stored and the resulting count is at or above the trigger level, `fill_flag` is 1 from the next cycle on.
- R4: At a character tick where no byte is taken in, no byte was taken in at the previous tick, the queue is non-empty and the count is below the trigger, `ready_flag` becomes 1. A byte counts as taken in when it is presented at a tick while reception is allowed, even if it is then dropped.
- R5: A byte taken in while the queue holds DEPTH bytes is dropped, the count is unchanged and `overrun` becomes 1.
- R6: `err_irq` is 1 exactly when `overrun` is 1 and either `rxi_en` or `erri_en` is 1.
- R7: `rx_irq` is 1 exactly when `rxi_en` is 1 and `fill_flag` or `ready_flag` is 1.
- R8: No byte is taken in while `rx_en` is 0 or `overrun` is 1.
- R9: A `fifo_clr` pulse empties the queue, sets the count to 0 and clears `fill_flag`, `ready_flag` and hence `rx_irq`; `overrun` is kept.
- R10: A `sts_wr` pulse ANDs `fill_flag` with `sts_wdata[1]` and `ready_flag` with `sts_wdata[0]`; writing 1 leaves a flag as it is. A flag set event in the same cycle wins over the clear.
- R11: An `ovr_wr` pulse with `ovr_wdata` 0 clears `overrun`; with `ovr_wdata` 1 it has no effect.
- R12: With the queue empty, `rd_data` reads 0x00 and a read strobe changes neither count nor order of later bytes.
- R13: With `loop_en` 1 the byte source is `loop_vld`/`loop_data`; with `loop_en` 0 it is `line_vld`/`line_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_tick | input | 1 | One-cycle strobe per character time |
| loop_en | input | 1 | Select the loopback byte source |
| line_vld | input | 1 | Deserializer has a byte at this tick |
| line_data | input | DATA_W | Deserializer byte |
| loop_vld | input | 1 | Transmit side has a byte at this tick |
| loop_data | input | DATA_W | Loopback byte |
| rx_en | input | 1 | Reception enable |
| rxi_en | input | 1 | Receive interrupt enable |
| erri_en | input | 1 | Receive-error interrupt enable |
| trig_sel | input | 2 | Trigger level select |
| fifo_clr | input | 1 | Queue reset pulse |
| rd_en | input | 1 | Read strobe, pops the oldest byte |
| rd_data | output | DATA_W | Oldest stored byte, 0 when empty |
| sts_wr | input | 1 | Status flag clear strobe |
| sts_wdata | input | 2 | Bit 1 fill flag, bit 0 data-ready flag |
| ovr_wr | input | 1 | Overrun flag clear strobe |
| ovr_wdata | input | 1 | Overrun write value |
| rx_count | output | CNT_W | Number of stored bytes |
| fill_flag | output | 1 | Trigger level reached |
| ready_flag | output | 1 | Data waiting below trigger after quiet line |
| overrun | output | 1 | Byte lost to a full queue |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults, 8-bit bytes and 16 entries, which is small enough to fill the queue completely under every one of the four trigger selections and compare the fill flag against the count at each step. With 16 entries the overrun, drop and blocked-reception cases are reached after a short fill, and the two-tick quiet window for the data-ready flag is walked tick by tick. Loopback, empty reads and the write-to-clear rules are driven at these same settings.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // Trigger level for a 2-bit selection code.
   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   localparam int unsigned MAX_TRIG = 14;

endpackage

// File: rtl/rxf_src.sv
module rxf_src #(
   parameter int DATA_W = 8
) (
   input  logic              char_tick,
   input  logic              loop_en,
   input  logic              line_vld,
   input  logic [DATA_W-1:0] line_data,
   input  logic              loop_vld,
   input  logic [DATA_W-1:0] loop_data,
   input  logic              rx_en,
   input  logic              overrun,
   output logic              take,
   output logic [DATA_W-1:0] byte_in
);

   logic src_vld;

   always_comb begin
      if (loop_en) begin
         src_vld = loop_vld;
         byte_in = loop_data;
      end else begin
         src_vld = line_vld;
         byte_in = line_data;
      end
      // R8: reception allowed only when enabled and no overrun pending
      take = char_tick && src_vld && rx_en && !overrun;
   end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 16,
   parameter int CNT_W         = 5,
   parameter bit CLEAR_STORAGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  count_nxt,
   output logic              full,
   output logic              empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full && !clr;
   assign pop_ok  = pop && !empty && !clr;
   assign rdata   = empty ? '0 : mem[rd_ptr];

   always_comb begin
      if (clr) count_nxt = '0;
      else     count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         count <= count_nxt;
         if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         end
      end
   end

   generate
      if (CLEAR_STORAGE) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (push_ok) begin
               mem[wr_ptr] <= wdata;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (push_ok) mem[wr_ptr] <= wdata;
         end
      end
   endgenerate

   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r5_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

   a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> (count == '0));

   a_r9_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             char_tick,
   input  logic             take,
   input  logic             clr,
   input  logic             store_full,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] count_nxt,
   input  logic [CNT_W-1:0] trig,
   input  logic             sts_wr,
   input  logic [1:0]       sts_wdata,
   input  logic             ovr_wr,
   input  logic             ovr_wdata,
   input  logic             rxi_en,
   input  logic             erri_en,
   output logic             fill_q,
   output logic             ready_q,
   output logic             ovr_q,
   output logic             rx_irq,
   output logic             err_irq
);

   logic took_last;
   logic stored, fill_set, ready_set, ovr_set;

   assign stored    = take && !store_full && !clr;
   assign fill_set  = stored && (count_nxt >= trig);
   assign ready_set = char_tick && !take && !took_last && !clr &&
                      (count != '0) && (count < trig);
   assign ovr_set   = take && store_full && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= 1'b0;
         ready_q   <= 1'b0;
         ovr_q     <= 1'b0;
         took_last <= 1'b0;
      end else begin
         if (char_tick) took_last <= take;

         if (clr)           fill_q <= 1'b0;
         else if (fill_set) fill_q <= 1'b1;
         else if (sts_wr)   fill_q <= fill_q & sts_wdata[1];

         if (clr)            ready_q <= 1'b0;
         else if (ready_set) ready_q <= 1'b1;
         else if (sts_wr)    ready_q <= ready_q & sts_wdata[0];

         if (ovr_set)     ovr_q <= 1'b1;
         else if (ovr_wr) ovr_q <= ovr_q & ovr_wdata;
      end
   end

   assign rx_irq  = rxi_en & (fill_q | ready_q);
   assign err_irq = (rxi_en | erri_en) & ovr_q;

   a_r3_fill_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_q) |-> $past(take));

   a_r4_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> ($past(char_tick) && $past(count) != '0));

   a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (take && store_full && !clr) |=> ovr_q);

   a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!fill_q && !ready_q && !rx_irq));

   a_r11_ovr_write_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && ovr_wr && ovr_wdata) |=> ovr_q);

endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 16,
   parameter bit CLEAR_STORAGE = 1'b0,
   localparam int CNT_W        = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_tick,
   input  logic              loop_en,
   input  logic              line_vld,
   input  logic [DATA_W-1:0] line_data,
   input  logic              loop_vld,
   input  logic [DATA_W-1:0] loop_data,
   input  logic              rx_en,
   input  logic              rxi_en,
   input  logic              erri_en,
   input  logic [1:0]        trig_sel,
   input  logic              fifo_clr,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sts_wr,
   input  logic [1:0]        sts_wdata,
   input  logic              ovr_wr,
   input  logic              ovr_wdata,
   output logic [CNT_W-1:0]  rx_count,
   output logic              fill_flag,
   output logic              ready_flag,
   output logic              overrun,
   output logic              rx_irq,
   output logic              err_irq
);

   import rxf_pkg::*;

   generate
      if (DEPTH < int'(MAX_TRIG)) begin : g_bad_depth
         $error("rx_trigger_fifo: DEPTH must cover the largest trigger level");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_trigger_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              take;
   logic [DATA_W-1:0] byte_in;
   logic [CNT_W-1:0]  count_nxt;
   logic [CNT_W-1:0]  trig;
   logic              store_full, store_empty;

   assign trig = CNT_W'(trig_level(trig_sel));

   rxf_src #(.DATA_W(DATA_W)) u_src (
      .char_tick (char_tick),
      .loop_en   (loop_en),
      .line_vld  (line_vld),
      .line_data (line_data),
      .loop_vld  (loop_vld),
      .loop_data (loop_data),
      .rx_en     (rx_en),
      .overrun   (overrun),
      .take      (take),
      .byte_in   (byte_in)
   );

   rxf_store #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .CNT_W         (CNT_W),
      .CLEAR_STORAGE (CLEAR_STORAGE)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .push      (take),
      .wdata     (byte_in),
      .pop       (rd_en),
      .rdata     (rd_data),
      .count     (rx_count),
      .count_nxt (count_nxt),
      .full      (store_full),
      .empty     (store_empty)
   );

   rxf_flags #(.CNT_W(CNT_W)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_tick  (char_tick),
      .take       (take),
      .clr        (fifo_clr),
      .store_full (store_full),
      .count      (rx_count),
      .count_nxt  (count_nxt),
      .trig       (trig),
      .sts_wr     (sts_wr),
      .sts_wdata  (sts_wdata),
      .ovr_wr     (ovr_wr),
      .ovr_wdata  (ovr_wdata),
      .rxi_en     (rxi_en),
      .erri_en    (erri_en),
      .fill_q     (fill_flag),
      .ready_q    (ready_flag),
      .ovr_q      (overrun),
      .rx_irq     (rx_irq),
      .err_irq    (err_irq)
   );

   a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (char_tick && (!rx_en || overrun) && !rd_en && !fifo_clr) |=> $stable(rx_count));

   a_r12_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      store_empty |-> (rd_data == '0));

endmodule

// File: tb/sim_rx_trigger_fifo.sv
`timescale 1ns/1ps
module sim_rx_trigger_fifo;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_tick = 0, loop_en = 0, line_vld = 0, loop_vld = 0;
   logic [7:0] line_data = 0, loop_data = 0;
   logic       rx_en = 1, rxi_en = 0, erri_en = 0;
   logic [1:0] trig_sel = 0;
   logic       fifo_clr = 0, rd_en = 0, sts_wr = 0, ovr_wr = 0, ovr_wdata = 0;
   logic [1:0] sts_wdata = 0;
   logic [7:0] rd_data;
   logic [4:0] rx_count;
   logic       fill_flag, ready_flag, overrun, rx_irq, err_irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rx_trigger_fifo u0 (
      .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .loop_en(loop_en),
      .line_vld(line_vld), .line_data(line_data), .loop_vld(loop_vld),
      .loop_data(loop_data), .rx_en(rx_en), .rxi_en(rxi_en), .erri_en(erri_en),
      .trig_sel(trig_sel), .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_data(rd_data),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
      .rx_count(rx_count), .fill_flag(fill_flag), .ready_flag(ready_flag),
      .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int trig_of(input int sel);
      case (sel)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic tick(input bit lv, input logic [7:0] ld, input bit pv, input logic [7:0] pd);
      @(negedge clk);
      char_tick = 1; line_vld = lv; line_data = ld; loop_vld = pv; loop_data = pd;
      @(negedge clk);
      char_tick = 0; line_vld = 0; loop_vld = 0;
   endtask

   task automatic rd(output logic [7:0] val);
      @(negedge clk);
      val = rd_data; rd_en = 1;
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic sts(input logic [1:0] v);
      @(negedge clk); sts_wr = 1; sts_wdata = v;
      @(negedge clk); sts_wr = 0;
   endtask

   task automatic ovw(input logic v);
      @(negedge clk); ovr_wr = 1; ovr_wdata = v;
      @(negedge clk); ovr_wr = 0;
   endtask

   task automatic clr();
      @(negedge clk); fifo_clr = 1;
      @(negedge clk); fifo_clr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // Reset state
      chk("R1 reset count", rx_count, 0);
      chk("R3 reset fill", fill_flag, 0);
      chk("R4 reset ready", ready_flag, 0);
      chk("R5 reset overrun", overrun, 0);
      chk("R7 reset rx_irq", rx_irq, 0);
      chk("R6 reset err_irq", err_irq, 0);
      chk("R12 reset rd_data", rd_data, 0);

      // R2/R3/R7/R1: sweep every trigger selection over a full fill
      rxi_en = 1;
      for (int s = 0; s < 4; s++) begin
         clr();
         sts(2'b00);
         trig_sel = 2'(s);
         for (int n = 1; n <= 16; n++) begin
            tick(1, 8'(n * 7 + s), 0, 0);
            chk("R1 count", rx_count, n);
            chk("R2 R3 fill vs trigger", fill_flag, int'(n >= trig_of(s)));
            chk("R7 rx_irq", rx_irq, int'(n >= trig_of(s)));
         end
         for (int n = 1; n <= 16; n++) begin
            rd(v);
            chk("R1 order", v, 8'(n * 7 + s));
         end
         chk("R1 drained", rx_count, 0);
      end

      // R5/R6/R8/R11 overrun
      rxi_en = 0;
      clr(); sts(2'b00);
      trig_sel = 3;
      for (int n = 1; n <= 16; n++) tick(1, 8'(n), 0, 0);
      tick(1, 8'hAA, 0, 0);
      chk("R5 overrun set", overrun, 1);
      chk("R5 count kept", rx_count, 16);
      chk("R6 err_irq no enable", err_irq, 0);
      erri_en = 1; @(negedge clk);
      chk("R6 err_irq error enable", err_irq, 1);
      erri_en = 0; rxi_en = 1; @(negedge clk);
      chk("R6 err_irq rx enable", err_irq, 1);
      rxi_en = 0;
      rd(v);
      chk("R5 first byte", v, 1);
      tick(1, 8'h77, 0, 0);
      chk("R8 blocked by overrun", rx_count, 15);
      ovw(1'b1);
      chk("R11 write one keeps", overrun, 1);
      ovw(1'b0);
      chk("R11 write zero clears", overrun, 0);
      tick(1, 8'h55, 0, 0);
      chk("R11 reception resumes", rx_count, 16);
      for (int n = 2; n <= 16; n++) begin
         rd(v);
         chk("R5 dropped byte absent", v, n);
      end
      rd(v);
      chk("R5 byte after clear", v, 8'h55);

      // R8 receive enable off
      rx_en = 0;
      tick(1, 8'h33, 0, 0);
      chk("R8 rx_en off", rx_count, 0);
      rx_en = 1;

      // R4/R10 data-ready timeout
      clr(); sts(2'b00);
      trig_sel = 1; rxi_en = 1;
      tick(1, 8'h42, 0, 0);
      chk("R4 not after byte", ready_flag, 0);
      tick(0, 0, 0, 0);
      chk("R4 not after one quiet tick", ready_flag, 0);
      chk("R7 no irq yet", rx_irq, 0);
      tick(0, 0, 0, 0);
      chk("R4 set after two quiet ticks", ready_flag, 1);
      chk("R7 irq from ready", rx_irq, 1);
      sts(2'b11);
      chk("R10 write ones keeps", ready_flag, 1);
      sts(2'b10);
      chk("R10 write zero clears ready", ready_flag, 0);
      chk("R10 fill untouched", fill_flag, 0);

      // R9 clear
      for (int n = 0; n < 3; n++) tick(1, 8'(n), 0, 0);
      chk("R3 fill at four", fill_flag, 1);
      clr();
      chk("R9 count", rx_count, 0);
      chk("R9 fill", fill_flag, 0);
      chk("R9 ready", ready_flag, 0);
      chk("R9 rx_irq", rx_irq, 0);

      // R12 empty read
      rd(v);
      chk("R12 empty data", v, 0);
      chk("R12 count unchanged", rx_count, 0);
      tick(1, 8'hC3, 0, 0);
      chk("R12 count after push", rx_count, 1);
      rd(v);
      chk("R12 pointer intact", v, 8'hC3);

      // R13 loopback source select
      loop_en = 1;
      tick(1, 8'h11, 1, 8'h22);
      rd(v);
      chk("R13 loopback byte", v, 8'h22);
      loop_en = 0;
      tick(1, 8'h11, 1, 8'h22);
      rd(v);
      chk("R13 line byte", v, 8'h11);

      finish_run();
   end

endmodule